// File: doc/BRIEF.md
# Sparse Readout for a 256-Pixel Group

This block reads out one group of pixels, 256 of them by default. Each pixel presents a 5-bit count. The block finds the unmasked pixel with the highest address whose count is not zero. When a readout request is accepted, it serializes that pixel's address and count into a short frame. It also sends a one-cycle swap pulse, with the pixel's address, so that the pixel changes to its other counter. A chip holds several independent copies of the block, 16 in a full array, and each copy drives its own serial line.

The selection is made again after every swap. If the counter the pixel now shows is non-zero, the same pixel is reported again. Once its count reads zero, the encoder moves to the next lower address that is still active. A group-level hit output shows whether any unmasked pixel still has a non-zero count. The requester must wait for the ready output before it issues the next request. A request made while ready is high but no pixel is active raises an error pulse.

Top module: `pixgrp_readout`

## Requirements
- R1: When a request is accepted, the frame carries the highest address among the pixels that are unmasked and have a non-zero count, together with that pixel's count.
- R2: A frame is 14 bits, one per clock. The first bit is a start bit of 1. The 8-bit address follows, most significant bit first, and then the 5-bit count, most significant bit first. The frame flag is high for exactly those 14 cycles. The data line is low whenever no frame is being sent.
- R3: A request is accepted only while ready is high. Ready falls at acceptance and stays low until the frame has been sent and one settle cycle has passed. Requests made while ready is low are ignored.
- R4: Every accepted request produces exactly one swap pulse, one cycle long, in the cycle after acceptance. The swap address equals the address sent in that frame.
- R5: After a swap, the same pixel is selected again if its newly visible count is non-zero, and that count is sent in the next frame.
- R6: A pixel whose mask bit is set is never selected and never drives the hit output, whatever its count.
- R7: The hit output is high one cycle after any unmasked pixel shows a non-zero count. It is low one cycle after all unmasked pixels read zero.
- R8: A request made while ready is high and the hit output is low produces a one-cycle error pulse in the next cycle. It produces no frame and no swap pulse.
- R9: After reset, ready is high and the hit, swap, error, frame flag and data outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_cnt_i | input | NPIX*CW | Visible count of every pixel; pixel i occupies bits [i*CW +: CW] |
| pix_mask_i | input | NPIX | Mask bit per pixel; 1 removes the pixel from selection |
| rd_req_i | input | 1 | Readout request, sampled on the rising clock edge |
| rd_ready_o | output | 1 | High when a request can be accepted |
| hit_or_o | output | 1 | High while any unmasked pixel has a non-zero count |
| swap_stb_o | output | 1 | One-cycle pulse telling the addressed pixel to swap counters |
| swap_addr_o | output | AW | Address of the pixel that swap_stb_o targets |
| ser_data_o | output | 1 | Serial frame data, low when idle |
| ser_frame_o | output | 1 | High while a frame bit is on ser_data_o |
| strobe_err_o | output | 1 | One-cycle pulse after a request made with no active pixel |

## Verification
Some properties are checked on every cycle. The swap is always a single-cycle pulse, and requests made while not ready never start one. Every frame opens with a 1 on the data line. A request made with no active pixel gives an error and no swap. The swap address does not change during a readout. The hit output always comes with a non-zero selected count. The serializer is never reloaded in the middle of a frame. Only the directed scenarios can show the rest: that the highest unmasked pixel wins, that the bit order is correct, that a pixel is read again after a non-zero swap, and that masked pixels stay silent.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

   typedef enum logic [1:0] {
      PG_IDLE   = 2'd0,
      PG_SEND   = 2'd1,
      PG_SETTLE = 2'd2
   } pg_state_e;

   // Frame length: start bit, address field, count field.
   function automatic int pg_frame_bits(input int aw, input int cw);
      return 1 + aw + cw;
   endfunction

endpackage

// File: rtl/pgr_prio_sel.sv
module pgr_prio_sel #(
   parameter int NPIX    = 256,
   parameter int CW      = 5,
   parameter int AW      = 8,
   parameter int REG_OUT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPIX*CW-1:0] cnt_flat_i,
   input  logic [NPIX-1:0]    mask_i,
   output logic               hit_o,
   output logic [AW-1:0]      sel_addr_o,
   output logic [CW-1:0]      sel_cnt_o
);

   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_regout
      $error("pgr_prio_sel: REG_OUT must be 0 or 1");
   end
   if ((1 << AW) < NPIX) begin : g_bad_aw
      $error("pgr_prio_sel: AW too narrow for NPIX");
   end

   logic [NPIX-1:0] act;

   for (genvar gi = 0; gi < NPIX; gi++) begin : g_act
      assign act[gi] = (|cnt_flat_i[gi*CW +: CW]) & ~mask_i[gi];
   end

   logic          c_hit;
   logic [AW-1:0] c_addr;
   logic [CW-1:0] c_cnt;

   // Ascending scan: the last active index found is the highest one.
   always_comb begin
      c_hit  = |act;
      c_addr = '0;
      c_cnt  = '0;
      for (int i = 0; i < NPIX; i++) begin
         if (act[i]) begin
            c_addr = AW'(i);
            c_cnt  = cnt_flat_i[i*CW +: CW];
         end
      end
   end

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_o      <= 1'b0;
            sel_addr_o <= '0;
            sel_cnt_o  <= '0;
         end else begin
            hit_o      <= c_hit;
            sel_addr_o <= c_addr;
            sel_cnt_o  <= c_cnt;
         end
      end
   end else begin : g_comb
      assign hit_o      = c_hit;
      assign sel_addr_o = c_addr;
      assign sel_cnt_o  = c_cnt;
   end

   // R7: an active group always presents a non-zero selected count
   p_hit_has_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (sel_cnt_o != '0));

endmodule

// File: rtl/pgr_serializer.sv
module pgr_serializer import pgr_pkg::*; #(
   parameter int AW = 8,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] addr_i,
   input  logic [CW-1:0] cnt_i,
   output logic          sdo_o,
   output logic          frame_o
);

   localparam int FL = pg_frame_bits(AW, CW);
   localparam int BW = $clog2(FL + 1);

   logic [FL-1:0] shreg;
   logic [BW-1:0] bits_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bits_left <= '0;
      end else if (load_i) begin
         shreg     <= {1'b1, addr_i, cnt_i};
         bits_left <= BW'(FL);
      end else if (bits_left != '0) begin
         shreg     <= shreg << 1;
         bits_left <= bits_left - 1'b1;
      end
   end

   assign frame_o = (bits_left != '0);
   assign sdo_o   = frame_o & shreg[FL-1];

   // R2: every frame opens with a start bit of one
   p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_o) |-> sdo_o);

   // R3: the controller never reloads during a frame
   p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !frame_o);

endmodule

// File: rtl/pgr_strobe_ctrl.sv
module pgr_strobe_ctrl import pgr_pkg::*; #(
   parameter int AW         = 8,
   parameter int SETTLE_CYC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req_i,
   input  logic          hit_i,
   input  logic [AW-1:0] sel_addr_i,
   input  logic          frame_i,
   output logic          ready_o,
   output logic          load_o,
   output logic          swap_stb_o,
   output logic [AW-1:0] swap_addr_o,
   output logic          err_o
);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("pgr_strobe_ctrl: SETTLE_CYC must be at least 1");
   end

   localparam int SW = $clog2(SETTLE_CYC + 1);

   pg_state_e     st;
   logic [SW-1:0] settle_left;

   assign ready_o = (st == PG_IDLE);
   assign load_o  = ready_o & rd_req_i & hit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= PG_IDLE;
         settle_left <= '0;
         swap_stb_o  <= 1'b0;
         swap_addr_o <= '0;
         err_o       <= 1'b0;
      end else begin
         swap_stb_o <= load_o;
         err_o      <= ready_o & rd_req_i & ~hit_i;
         if (load_o) begin
            swap_addr_o <= sel_addr_i;
         end
         case (st)
            PG_IDLE: begin
               if (load_o) st <= PG_SEND;
            end
            PG_SEND: begin
               if (!frame_i) begin
                  st          <= PG_SETTLE;
                  settle_left <= SW'(SETTLE_CYC - 1);
               end
            end
            PG_SETTLE: begin
               if (settle_left == '0) st <= PG_IDLE;
               else                   settle_left <= settle_left - 1'b1;
            end
            default: st <= PG_IDLE;
         endcase
      end
   end

   // R4: the swap is a single-cycle pulse
   p_swap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      swap_stb_o |=> !swap_stb_o);

   // R3: a request while busy never starts a swap
   p_busy_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && !ready_o) |=> !swap_stb_o);

   // R8: a request with no active pixel flags an error, no swap
   p_empty_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && ready_o && !hit_i) |=> (err_o && !swap_stb_o));

   // R4: the target address holds through the readout
   p_swap_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && !swap_stb_o) |-> $stable(swap_addr_o));

endmodule

// File: rtl/pixgrp_readout.sv
module pixgrp_readout #(
   parameter int NPIX       = 256,
   parameter int CW         = 5,
   parameter int SETTLE_CYC = 1,
   parameter int REG_SEL    = 1,
   localparam int AW        = $clog2(NPIX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPIX*CW-1:0] pix_cnt_i,
   input  logic [NPIX-1:0]    pix_mask_i,
   input  logic               rd_req_i,
   output logic               rd_ready_o,
   output logic               hit_or_o,
   output logic               swap_stb_o,
   output logic [AW-1:0]      swap_addr_o,
   output logic               ser_data_o,
   output logic               ser_frame_o,
   output logic               strobe_err_o
);

   if (NPIX < 2 || (NPIX & (NPIX - 1)) != 0) begin : g_bad_npix
      $error("pixgrp_readout: NPIX must be a power of two, at least 2");
   end
   if (CW < 1) begin : g_bad_cw
      $error("pixgrp_readout: CW must be at least 1");
   end

   logic          hit;
   logic [AW-1:0] sel_addr;
   logic [CW-1:0] sel_cnt;
   logic          load;

   pgr_prio_sel #(
      .NPIX    (NPIX),
      .CW      (CW),
      .AW      (AW),
      .REG_OUT (REG_SEL)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_flat_i (pix_cnt_i),
      .mask_i     (pix_mask_i),
      .hit_o      (hit),
      .sel_addr_o (sel_addr),
      .sel_cnt_o  (sel_cnt)
   );

   pgr_strobe_ctrl #(
      .AW         (AW),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_req_i    (rd_req_i),
      .hit_i       (hit),
      .sel_addr_i  (sel_addr),
      .frame_i     (ser_frame_o),
      .ready_o     (rd_ready_o),
      .load_o      (load),
      .swap_stb_o  (swap_stb_o),
      .swap_addr_o (swap_addr_o),
      .err_o       (strobe_err_o)
   );

   pgr_serializer #(
      .AW (AW),
      .CW (CW)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .addr_i  (sel_addr),
      .cnt_i   (sel_cnt),
      .sdo_o   (ser_data_o),
      .frame_o (ser_frame_o)
   );

   assign hit_or_o = hit;

   // R2: the line is low outside a frame
   p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_frame_o |-> !ser_data_o);

endmodule

// File: tb/pixgrp_readout_bench.sv
module pixgrp_readout_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NPIX = 256;
   localparam int CW   = 5;
   localparam int AW   = 8;
   localparam int FL   = 1 + AW + CW;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NPIX*CW-1:0] pix_cnt;
   logic [NPIX-1:0]    pix_mask = '0;
   logic               rd_req = 1'b0;
   logic               rd_ready, hit_or, swap_stb, ser_data, ser_frame, strobe_err;
   logic [AW-1:0]      swap_addr;

   logic [CW-1:0] vis [NPIX];
   logic [CW-1:0] nxt [NPIX];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NPIX; i++) pix_cnt[i*CW +: CW] = vis[i];
   end

   pixgrp_readout u_pixgrp_readout (
      .clk          (clk),
      .rst_n        (rst_n),
      .pix_cnt_i    (pix_cnt),
      .pix_mask_i   (pix_mask),
      .rd_req_i     (rd_req),
      .rd_ready_o   (rd_ready),
      .hit_or_o     (hit_or),
      .swap_stb_o   (swap_stb),
      .swap_addr_o  (swap_addr),
      .ser_data_o   (ser_data),
      .ser_frame_o  (ser_frame),
      .strobe_err_o (strobe_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_pixels();
      for (int i = 0; i < NPIX; i++) begin
         vis[i] = '0;
         nxt[i] = '0;
      end
      pix_mask = '0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_ready();
      while (!rd_ready) @(negedge clk);
   endtask

   // One readout; poke_busy adds requests while the frame is in flight.
   task automatic do_frame(input string req, input int ea, input int ec, input bit poke_busy);
      logic [FL-1:0] got;
      logic [FL-1:0] exp;
      int swaps;
      bit busy_ok;
      bit swap_ok;
      exp = {1'b1, AW'(ea), CW'(ec)};
      got = '0;
      swaps = 0;
      busy_ok = 1'b1;
      swap_ok = 1'b0;
      wait_ready();
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      for (int k = 0; k < FL; k++) begin
         if (swap_stb) begin
            swaps++;
            if (k == 0 && swap_addr == AW'(ea)) swap_ok = 1'b1;
            vis[swap_addr] = nxt[swap_addr];
            nxt[swap_addr] = '0;
         end
         if (!ser_frame || rd_ready) busy_ok = 1'b0;
         got[FL-1-k] = ser_data;
         if (poke_busy) rd_req = (k >= 2 && k < 6);
         @(negedge clk);
      end
      rd_req = 1'b0;
      chk(got == exp, {req, " R1/R2 frame content"}, int'(got), int'(exp));
      chk(!ser_frame && !ser_data, {req, " R2 line idle after frame"},
          int'({ser_frame, ser_data}), 0);
      chk(busy_ok, {req, " R3 ready low and flag high during frame"}, int'(busy_ok), 1);
      chk(swap_ok && swaps == 1, {req, " R4 single swap to frame address"}, swaps, 1);
   endtask

   task automatic t_reset();
      chk(rd_ready && !hit_or && !swap_stb && !strobe_err && !ser_frame && !ser_data,
          "R9 reset state",
          int'({rd_ready, hit_or, swap_stb, strobe_err, ser_frame, ser_data}), 6'b100000);
   endtask

   task automatic t_single();
      clear_pixels();
      vis[37] = 5'd9;
      settle();
      chk(hit_or, "R7 hit on single pixel", int'(hit_or), 1);
      do_frame("single", 37, 9, 1'b0);
      wait_ready();
      chk(!hit_or, "R7 hit low when drained", int'(hit_or), 0);
   endtask

   task automatic t_priority();
      clear_pixels();
      vis[3] = 5'd1;  vis[200] = 5'd17; vis[255] = 5'd31; vis[128] = 5'd4;
      settle();
      do_frame("prio R1 255", 255, 31, 1'b0);
      do_frame("prio R1 200", 200, 17, 1'b0);
      do_frame("prio R1 128", 128, 4, 1'b0);
      do_frame("prio R1 3", 3, 1, 1'b0);
      wait_ready();
      chk(!hit_or, "R7 hit low after priority drain", int'(hit_or), 0);
   endtask

   task automatic t_reexamine();
      clear_pixels();
      vis[90] = 5'd6; nxt[90] = 5'd11; vis[10] = 5'd2;
      settle();
      do_frame("R5 first read", 90, 6, 1'b0);
      do_frame("R5 same pixel again", 90, 11, 1'b0);
      do_frame("R5 moves on", 10, 2, 1'b0);
   endtask

   task automatic t_mask();
      clear_pixels();
      vis[250] = 5'd7; vis[5] = 5'd3;
      pix_mask[250] = 1'b1;
      settle();
      do_frame("R6 masked skipped", 5, 3, 1'b0);
      wait_ready();
      settle();
      chk(!hit_or, "R6 masked pixel keeps hit low", int'(hit_or), 0);
      pix_mask[250] = 1'b0;
      settle();
      chk(hit_or, "R7 hit after unmask", int'(hit_or), 1);
      do_frame("R6 unmasked read", 250, 7, 1'b0);
   endtask

   task automatic t_busy_ignore();
      clear_pixels();
      vis[60] = 5'd1; vis[61] = 5'd2;
      settle();
      do_frame("R3 busy requests", 61, 2, 1'b1);
      wait_ready();
      chk(hit_or, "R3 remaining pixel untouched", int'(hit_or), 1);
      do_frame("R3 next after busy", 60, 1, 1'b0);
   endtask

   task automatic t_err();
      clear_pixels();
      settle();
      wait_ready();
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk(strobe_err && !swap_stb && !ser_frame, "R8 error on empty request",
          int'({strobe_err, swap_stb, ser_frame}), 3'b100);
      @(negedge clk);
      chk(!strobe_err && rd_ready, "R8 error is one cycle", int'({strobe_err, rd_ready}), 2'b01);
   endtask

   task automatic t_pattern();
      clear_pixels();
      vis[170] = 5'd10; vis[0] = 5'd21;
      settle();
      do_frame("R2 alternating bits", 170, 10, 1'b0);
      do_frame("R2 address zero", 0, 21, 1'b0);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      clear_pixels();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_priority();
      t_reexamine();
      t_mask();
      t_busy_ignore();
      t_err();
      t_pattern();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         report();
      end
   end

endmodule